// File: doc/BRIEF.md
# Halt-mode power and wakeup controller

This block sequences a microcontroller core into and out of its deepest low-power state. While the core runs, it produces a divide-by-three clock enable that paces the CPU and the peripherals. A one-cycle halt strobe from the CPU does three things: it drops the oscillator enable, it gates both clock enables, and it clears the interrupt mask bit so that a waking interrupt can be taken.

Three events can end the halt: an external interrupt line, a USB end-of-suspend event, or a reset request. Each of these inputs passes through a two-flop synchronizer. On a wake the block raises the oscillator enable again. It then holds the clocks gated for a fixed stabilization window, counted on the free-running reference clock. At the end of the window it releases the clocks and issues one of two one-cycle results. An interrupt wake asks the core to service the interrupt. A reset wake asks the core to fetch the reset vector. Reset outranks the interrupt sources for the whole of the halt and the whole of the window. The interrupt mask bit is set when the service request is issued. It is cleared when the core returns from the interrupt.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, the block is running. `oscEn` is 1, `iBit` is 1, and `svcIrq` and `fetchVec` are 0.
- R2: While running, `cpuClkEn` and `periphClkEn` are high together for one cycle in every three reference clock cycles. They are never high in two consecutive cycles.
- R3: If `haltStb` is sampled high while the block is running, then from the next cycle `oscEn` is 0, both clock enables are 0 and `iBit` is 0.
- R4: In halt, `haltStb` and `retiStb` have no effect. `oscEn` stays 0 until a wake source is seen.
- R5: Each wake input passes through two synchronizing flops. A wake input sampled high at clock edge k raises `oscEn` after edge k+2. While the block is running, `extIrq` and `usbResume` are ignored: no result is issued and `iBit` is unchanged.
- R6: After a wake, `oscEn` is 1 and both clock enables stay 0 for exactly STAB_CYCLES reference cycles (default 4096). A result pulse follows in the very next cycle.
- R7: After an interrupt-only wake, `svcIrq` is high for exactly one cycle, `fetchVec` stays 0, and `iBit` becomes 1 in that same cycle. The clock enables then resume.
- R8: If `rstReq` is seen during the halt or during the stabilization window, the result is a one-cycle `fetchVec` and `svcIrq` stays 0. This holds when it arrives together with an interrupt, and when it arrives after an interrupt wake has already started the window.
- R9: While the block is running, `retiStb` sampled high clears `iBit` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock, alive during halt |
| rstN | input | 1 | Asynchronous active-low block reset |
| haltStb | input | 1 | One-cycle halt command from the CPU |
| retiStb | input | 1 | One-cycle return-from-interrupt strobe |
| extIrq | input | 1 | External interrupt wake line, asynchronous |
| usbResume | input | 1 | USB end-of-suspend wake event, asynchronous |
| rstReq | input | 1 | Reset wake request, asynchronous |
| oscEn | output | 1 | Oscillator enable |
| cpuClkEn | output | 1 | CPU clock enable (divide by three while running) |
| periphClkEn | output | 1 | Peripheral clock enable |
| iBit | output | 1 | Interrupt mask bit |
| svcIrq | output | 1 | One-cycle request to service the waking interrupt |
| fetchVec | output | 1 | One-cycle request to fetch the reset vector |

## Verification
The bench drives every input at a falling edge and samples the outputs at the falling edges that follow. After a halt or return strobe, the result is due at the next falling edge. After a wake input, `oscEn` is first seen high at the third falling edge. The window is then measured by counting falling edges that show `oscEn` high with no result. That count must equal STAB_CYCLES, and the result pulse must be gone at the next falling edge. The sweep covers every wake source, a simultaneous interrupt and reset, and a reset that arrives partway through the window.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRun;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic stabDone;
    logic extWake;
    logic usbWake;
    logic rstWake;
    logic divTick;
  } dpStat_t;
endpackage

// File: rtl/hw_datapath.sv
module hw_datapath
  import halt_wake_pkg::*;
#(
  parameter int STAB_CYCLES = 4096,
  parameter int DIV = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   extIrq,
  input  logic   usbResume,
  input  logic   rstReq,
  input  dpCtl_t ctl,
  output dpStat_t stat
);
  localparam int CNT_W = $clog2(STAB_CYCLES);
  localparam int DIV_W = $clog2(DIV);
  localparam int NSRC = 3;

  logic [NSRC-1:0] rawIn;
  logic [NSRC-1:0] syncOut;
  assign rawIn = {rstReq, usbResume, extIrq};

  for (genvar s = 0; s < NSRC; s++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[s]};
    end
    assign syncOut[s] = chain[SYNC_STAGES-1];
  end

  logic [DIV_W-1:0] divCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            divCnt <= '0;
    else if (divCnt == DIV_W'(DIV - 1))   divCnt <= '0;
    else                                  divCnt <= divCnt + 1'b1;
  end

  logic [CNT_W-1:0] stabCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           stabCnt <= '0;
    else if (ctl.cntRun) stabCnt <= stabCnt + 1'b1;
    else                 stabCnt <= '0;
  end

  assign stat.stabDone = ctl.cntRun && (stabCnt == CNT_W'(STAB_CYCLES - 1));
  assign stat.extWake  = syncOut[0];
  assign stat.usbWake  = syncOut[1];
  assign stat.rstWake  = syncOut[2];
  assign stat.divTick  = (divCnt == DIV_W'(DIV - 1));
endmodule

// File: rtl/hw_control.sv
module hw_control
  import halt_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      haltStb,
  input  logic      retiStb,
  input  dpStat_t   stat,
  output dpCtl_t    ctl,
  output pwrState_t state,
  output logic      iBit,
  output logic      svcIrq,
  output logic      fetchVec
);
  logic rstSeen;
  logic anyWake;
  logic rstNow;

  assign anyWake = stat.extWake | stat.usbWake | stat.rstWake;
  assign rstNow  = rstSeen | stat.rstWake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      rstSeen  <= 1'b0;
      iBit     <= 1'b1;
      svcIrq   <= 1'b0;
      fetchVec <= 1'b0;
    end else begin
      svcIrq   <= 1'b0;
      fetchVec <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (haltStb) begin
            state <= ST_HALT;
            iBit  <= 1'b0;
          end else if (retiStb) begin
            iBit <= 1'b0;
          end
        end
        ST_HALT: begin
          if (anyWake) begin
            state   <= ST_STAB;
            rstSeen <= stat.rstWake;
          end
        end
        ST_STAB: begin
          if (stat.stabDone) begin
            state    <= ST_RUN;
            rstSeen  <= 1'b0;
            svcIrq   <= ~rstNow;
            fetchVec <= rstNow;
            iBit     <= 1'b1;
          end else if (stat.rstWake) begin
            rstSeen <= 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign ctl.cntRun = (state == ST_STAB);
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
#(
  parameter int STAB_CYCLES = 4096,
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic haltStb,
  input  logic retiStb,
  input  logic extIrq,
  input  logic usbResume,
  input  logic rstReq,
  output logic oscEn,
  output logic cpuClkEn,
  output logic periphClkEn,
  output logic iBit,
  output logic svcIrq,
  output logic fetchVec
);
  dpCtl_t    ctl;
  dpStat_t   stat;
  pwrState_t state;

  hw_datapath #(.STAB_CYCLES(STAB_CYCLES), .DIV(DIV), .SYNC_STAGES(2)) dp_i (
    .clk(clk), .rstN(rstN), .extIrq(extIrq), .usbResume(usbResume),
    .rstReq(rstReq), .ctl(ctl), .stat(stat)
  );

  hw_control ctrl_i (
    .clk(clk), .rstN(rstN), .haltStb(haltStb), .retiStb(retiStb),
    .stat(stat), .ctl(ctl), .state(state), .iBit(iBit),
    .svcIrq(svcIrq), .fetchVec(fetchVec)
  );

  assign oscEn       = (state != ST_HALT);
  assign cpuClkEn    = (state == ST_RUN) && stat.divTick;
  assign periphClkEn = (state == ST_RUN) && stat.divTick;
endmodule

// File: rtl/hw_checker.sv
module hw_checker
  import halt_wake_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      haltStb,
  input logic      oscEn,
  input logic      cpuClkEn,
  input logic      periphClkEn,
  input logic      iBit,
  input logic      svcIrq,
  input logic      fetchVec,
  input pwrState_t state
);
  a_r3_halt_entry: assert property (@(posedge clk) disable iff (!rstN)
    (haltStb && state == ST_RUN) |=> (!oscEn && !iBit && !cpuClkEn && !periphClkEn));

  a_r2_cpu_spacing: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |=> !cpuClkEn);

  a_r2_periph_spacing: assert property (@(posedge clk) disable iff (!rstN)
    periphClkEn |=> !periphClkEn);

  a_r8_one_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({svcIrq, fetchVec}));

  a_r7_svc_masks: assert property (@(posedge clk) disable iff (!rstN)
    svcIrq |-> iBit);

  a_r6_result_after_stab: assert property (@(posedge clk) disable iff (!rstN)
    (svcIrq || fetchVec) |-> ($past(state) == ST_STAB));

  a_r4_wake_from_halt: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscEn) |-> ($past(state) == ST_HALT));
endmodule

bind halt_wake_ctrl hw_checker chk_i (
  .clk(clk), .rstN(rstN), .haltStb(haltStb), .oscEn(oscEn),
  .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .iBit(iBit),
  .svcIrq(svcIrq), .fetchVec(fetchVec), .state(state)
);

// File: tb/halt_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb_top;
  localparam int STAB = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltStb = 1'b0, retiStb = 1'b0;
  logic extIrq = 1'b0, usbResume = 1'b0, rstReq = 1'b0;
  logic oscEn, cpuClkEn, periphClkEn, iBit, svcIrq, fetchVec;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  halt_wake_ctrl #(.STAB_CYCLES(STAB), .DIV(3)) dut_i (
    .clk(clk), .rstN(rstN), .haltStb(haltStb), .retiStb(retiStb),
    .extIrq(extIrq), .usbResume(usbResume), .rstReq(rstReq),
    .oscEn(oscEn), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .iBit(iBit), .svcIrq(svcIrq), .fetchVec(fetchVec)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enterHalt();
    @(negedge clk) haltStb = 1'b1;
    @(negedge clk) haltStb = 1'b0;
    check("R3 oscEn off", oscEn, 0);
    check("R3 iBit cleared", iBit, 0);
    check("R3 clocks gated", cpuClkEn | periphClkEn, 0);
  endtask

  // src: 0 ext, 1 usb, 2 rst, 3 ext+rst together; lateRst: rstReq mid-window
  task automatic wakeRun(input int src, input bit lateRst);
    int n;
    int gatedBad;
    int sawEn;
    bit expRst;
    expRst = (src >= 2) || lateRst;
    @(negedge clk);
    extIrq = (src == 0 || src == 3);
    usbResume = (src == 1);
    rstReq = (src >= 2);
    @(negedge clk) check("R5 no early wake 1", oscEn, 0);
    @(negedge clk) check("R5 no early wake 2", oscEn, 0);
    @(negedge clk) check("R5 wake latency", oscEn, 1);
    extIrq = 1'b0; usbResume = 1'b0; rstReq = 1'b0;
    n = 1;
    gatedBad = cpuClkEn | periphClkEn;
    while (!(svcIrq || fetchVec) && n < STAB + 10) begin
      @(negedge clk);
      if (lateRst && n == 100) rstReq = 1'b1;
      if (lateRst && n == 103) rstReq = 1'b0;
      if (!(svcIrq || fetchVec)) begin
        n++;
        if (cpuClkEn || periphClkEn || !oscEn) gatedBad++;
      end
    end
    check("R6 window length", n, STAB);
    check("R6 gated in window", gatedBad, 0);
    if (expRst) begin
      check("R8 fetchVec issued", fetchVec, 1);
      check("R8 no svcIrq", svcIrq, 0);
    end else begin
      check("R7 svcIrq issued", svcIrq, 1);
      check("R7 no fetchVec", fetchVec, 0);
    end
    check("R7 iBit set", iBit, 1);
    sawEn = 0;
    @(negedge clk) check("R7 single-cycle result", svcIrq | fetchVec, 0);
    sawEn += cpuClkEn;
    @(negedge clk) sawEn += cpuClkEn;
    @(negedge clk) sawEn += cpuClkEn;
    check("R7 clocks resume", sawEn, 1);
  endtask

  initial begin
    int cCnt, pCnt, lastTick, spacingBad;
    repeat (3) @(negedge clk);
    check("R1 oscEn in reset", oscEn, 1);
    check("R1 iBit in reset", iBit, 1);
    check("R1 no result in reset", svcIrq | fetchVec, 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check("R1 oscEn after reset", oscEn, 1);
    check("R1 iBit after reset", iBit, 1);
    check("R1 no result after reset", svcIrq | fetchVec, 0);

    // R2 divide by three
    cCnt = 0; pCnt = 0; lastTick = -10; spacingBad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      cCnt += cpuClkEn;
      pCnt += periphClkEn;
      if (cpuClkEn != periphClkEn) spacingBad++;
      if (cpuClkEn) begin
        if (lastTick >= 0 && i - lastTick != 3) spacingBad++;
        lastTick = i;
      end
    end
    check("R2 cpu enables in 30", cCnt, 10);
    check("R2 periph enables in 30", pCnt, 10);
    check("R2 spacing and match", spacingBad, 0);

    // R5 interrupts ignored while running
    @(negedge clk) begin extIrq = 1'b1; usbResume = 1'b1; end
    repeat (4) @(negedge clk);
    extIrq = 1'b0; usbResume = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (svcIrq || fetchVec || !oscEn || !iBit) bad++;
      end
      check("R5 run ignores irq", bad, 0);
    end

    // sweep over wake sources
    for (int src = 0; src < 4; src++) begin
      enterHalt();
      // R4: halt and reti strobes in halt do nothing
      @(negedge clk) begin haltStb = 1'b1; retiStb = 1'b1; end
      @(negedge clk) begin haltStb = 1'b0; retiStb = 1'b0; end
      repeat (10) @(negedge clk);
      check("R4 stays halted", oscEn, 0);
      check("R4 iBit untouched", iBit, 0);
      wakeRun(src, 1'b0);
      // R9 return from interrupt
      @(negedge clk) retiStb = 1'b1;
      @(negedge clk) retiStb = 1'b0;
      check("R9 reti clears iBit", iBit, 0);
    end

    // R8 reset arriving after an interrupt wake started the window
    enterHalt();
    wakeRun(0, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule